// File: doc/BRIEF.md
# Mixed-polarity ripple toggle chain

This block models a four-stage chain of toggle flip-flops. The toggle input of every stage is tied high, so a stage changes state whenever its own clock source rises. An external stage clock drives the most significant stage. Each lower stage takes its clock from the stage directly above it, using either that stage's true output or its inverted output. A per-stage parameter picks the polarity. Because the taps can mix polarities, one external edge can give results that a binary counter never would, such as complementing every bit.

The real design runs on a single system clock. The external stage clock is synchronized into that domain and edge-detected. Within the same system cycle as a detected edge, the whole ripple is resolved from the most significant stage downward and then registered. A synchronous load presets the state, and an active-high synchronous reset clears it.

Top module: `mixpol_ripple_chain`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, all state bits become 0 at that edge. Reset has priority over load and over external edges.
- R2: When `load_en` is high at a rising edge of `clk` and reset is low, `state_q` takes the value of `load_val` at that edge. This happens even if an external edge is detected in the same cycle.
- R3: Each 0-to-1 transition of `ext_clk` toggles the most significant state bit exactly once. A 1-to-0 transition, or `ext_clk` holding steady at either level, leaves the whole state unchanged.
- R4: Below the most significant stage, stage i toggles only if its selected source (bit i+1 after that bit's own update, true or inverted) went from 0 to 1. Stages are resolved from most to least significant within one system cycle.
- R5: With the default taps, the state moves from 0110 to 1001 on one external edge. In the default taps, stage 2 uses the true output of stage 3, and stages 1 and 0 use the inverted outputs of stages 2 and 1.
- R6: If stage 1 uses the true output of stage 2 instead, the state moves from 0110 to 1010 on one external edge.
- R7: A rise of `ext_clk` shows up in `state_q` after the third rising edge of `clk` that follows the rise, and not before. This assumes `ext_clk` is driven between `clk` edges and held for at least three cycles.
- R8: In the `TAP_INV` parameter, bit i = 1 means stage i is clocked by the inverted output of stage i+1, and bit i = 0 means the true output. The top bit has no effect. The default value is 4'b0011.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high synchronous reset |
| ext_clk | input | 1 | External stage clock for the most significant stage (asynchronous) |
| load_en | input | 1 | Synchronous preset strobe |
| load_val | input | 4 | Value written to the state on load |
| state_q | output | 4 | Current stage outputs, bit 3 most significant |

## Verification
The chain is exercised from each of the 16 preset states, under the default taps and under the variant where stage 1 uses the true tap. This separates the polarity-dependent results from a plain binary increment or decrement. A small vector table pins the hand-derived cases 0110→1001, 0110→1010, 0000→1100, 0000→1110, 1111→0111 and 1000→0000. Together these show whether a falling intermediate source correctly stops the ripple. The falling external edge and a long high level are checked to prove that nothing toggles. A load held across a detected edge shows that the load wins. A two-versus-three cycle probe fixes the synchronizer latency.

// File: rtl/ripple_pkg.sv
package ripple_pkg;
    typedef enum logic {
        TAP_TRUE = 1'b0,
        TAP_INV  = 1'b1
    } tap_pol_e;

    function automatic logic src_level(input logic bit_v, input logic inv);
        return bit_v ^ inv;
    endfunction
endpackage

// File: rtl/tgl_sync.sv
module tgl_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int LAST = DEPTH - 1;

    logic [LAST:0] sh_d, sh_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb sh_d = din;
        end else begin : g_multi
            always_comb sh_d = {sh_q[LAST-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign dout = sh_q[LAST];
endmodule

// File: rtl/tgl_edge.sv
module tgl_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
        rise   = lvl & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/tgl_chain.sv
module tgl_chain
    import ripple_pkg::*;
#(
    parameter int                    NUM_STAGES = 4,
    parameter logic [NUM_STAGES-1:0] TAP_INV    = 4'b0011
) (
    input  logic [NUM_STAGES-1:0] cur,
    input  logic                  fire,
    output logic [NUM_STAGES-1:0] nxt
);
    localparam int TOP = NUM_STAGES - 1;

    logic [NUM_STAGES-1:0] work;
    logic                  src_old;
    logic                  src_new;

    // Resolve from the most significant stage downward; each stage sees the
    // already-updated value of the stage above it.
    always_comb begin
        work      = cur;
        work[TOP] = cur[TOP] ^ fire;
        src_old   = 1'b0;
        src_new   = 1'b0;
        for (int i = TOP - 1; i >= 0; i--) begin
            src_old = src_level(cur[i+1], TAP_INV[i]);
            src_new = src_level(work[i+1], TAP_INV[i]);
            work[i] = cur[i] ^ (~src_old & src_new);
        end
        nxt = work;
    end
endmodule

// File: rtl/mixpol_ripple_chain.sv
module mixpol_ripple_chain #(
    parameter int                    NUM_STAGES = 4,
    parameter int                    SYNC_DEPTH = 2,
    parameter logic [NUM_STAGES-1:0] TAP_INV    = 4'b0011
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ext_clk,
    input  logic                  load_en,
    input  logic [NUM_STAGES-1:0] load_val,
    output logic [NUM_STAGES-1:0] state_q
);
    typedef struct packed {
        logic [NUM_STAGES-1:0] stages;
    } chain_st_t;

    chain_st_t             st_d, st_q;
    logic                  ext_sync;
    logic                  edge_fire;
    logic [NUM_STAGES-1:0] chain_nxt;

    tgl_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (ext_clk),
        .dout (ext_sync)
    );

    tgl_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ext_sync),
        .rise (edge_fire)
    );

    tgl_chain #(.NUM_STAGES(NUM_STAGES), .TAP_INV(TAP_INV)) u_chain (
        .cur  (st_q.stages),
        .fire (edge_fire),
        .nxt  (chain_nxt)
    );

    always_comb begin
        st_d = st_q;
        if (load_en)        st_d.stages = load_val;
        else if (edge_fire) st_d.stages = chain_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state_q = st_q.stages;
endmodule

// File: rtl/mixpol_ripple_chain_chk.sv
module mixpol_ripple_chain_chk #(
    parameter int NUM_STAGES = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  fire,
    input logic                  load_en,
    input logic [NUM_STAGES-1:0] load_val,
    input logic [NUM_STAGES-1:0] state_q
);
    localparam int TOP = NUM_STAGES - 1;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> state_q == '0);

    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        load_en |=> state_q == $past(load_val));

    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (!fire && !load_en) |=> $stable(state_q));

    a_r3_msb_flips: assert property (@(posedge clk) disable iff (rst)
        (fire && !load_en) |=> state_q[TOP] != $past(state_q[TOP]));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);
endmodule

bind mixpol_ripple_chain mixpol_ripple_chain_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .fire     (edge_fire),
    .load_en  (load_en),
    .load_val (load_val),
    .state_q  (state_q)
);

// File: tb/sim_mixpol_ripple_chain.sv
module sim_mixpol_ripple_chain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'b0000;
    logic [3:0] st0, st1;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    mixpol_ripple_chain u0 (
        .clk(clk), .rst(rst), .ext_clk(ext_clk),
        .load_en(load_en), .load_val(load_val), .state_q(st0));

    mixpol_ripple_chain #(.TAP_INV(4'b0001)) u1 (
        .clk(clk), .rst(rst), .ext_clk(ext_clk),
        .load_en(load_en), .load_val(load_val), .state_q(st1));

    // {alt taps, start, expected}
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 4'b0110, 4'b1001},
        {1'b1, 4'b0110, 4'b1010},
        {1'b0, 4'b0000, 4'b1100},
        {1'b1, 4'b0000, 4'b1110},
        {1'b0, 4'b1111, 4'b0111},
        {1'b0, 4'b1000, 4'b0000}
    };

    function automatic logic [3:0] ref_next(input logic [3:0] s, input bit alt);
        logic [3:0] pol;
        logic [3:0] r;
        logic       a, b;
        pol  = alt ? 4'b0001 : 4'b0011;
        r    = s;
        r[3] = ~s[3];
        for (int k = 2; k >= 0; k--) begin
            a = s[k+1] ^ pol[k];
            b = r[k+1] ^ pol[k];
            if (!a && b) r[k] = ~s[k];
        end
        return r;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [3:0] v);
        load_en  = 1'b1;
        load_val = v;
        step(1);
        load_en  = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        step(3);
        chk("R1 reset state u0", st0, 4'b0000);
        chk("R1 reset state u1", st1, 4'b0000);
        rst = 1'b0;
        step(2);

        // vector table
        for (int v = 0; v < 6; v++) begin
            do_load(VEC[v][7:4]);
            ext_clk = 1'b1;
            step(5);
            if (VEC[v][8]) chk("R6 R8 table alt taps", st1, VEC[v][3:0]);
            else           chk("R5 R4 table default taps", st0, VEC[v][3:0]);
            ext_clk = 1'b0;
            step(5);
        end

        // exhaustive sweep of start states
        for (int s = 0; s < 16; s++) begin
            do_load(4'(s));
            chk("R2 load u0", st0, 4'(s));
            chk("R2 load u1", st1, 4'(s));
            ext_clk = 1'b1;
            step(5);
            chk("R4 R5 sweep default", st0, ref_next(4'(s), 1'b0));
            chk("R4 R8 sweep alt", st1, ref_next(4'(s), 1'b1));
            ext_clk = 1'b0;
            step(5);
            chk("R3 falling edge no change u0", st0, ref_next(4'(s), 1'b0));
            chk("R3 falling edge no change u1", st1, ref_next(4'(s), 1'b1));
        end

        // R7 latency probe
        do_load(4'b0110);
        ext_clk = 1'b1;
        step(2);
        chk("R7 not before third edge", st0, 4'b0110);
        step(1);
        chk("R7 after third edge", st0, 4'b1001);
        step(6);
        chk("R3 steady high no retoggle", st0, 4'b1001);
        ext_clk = 1'b0;
        step(5);

        // R2 load held across a detected edge
        load_en  = 1'b1;
        load_val = 4'b0101;
        ext_clk  = 1'b1;
        step(6);
        load_en  = 1'b0;
        step(4);
        chk("R2 load beats edge u0", st0, 4'b0101);
        chk("R2 load beats edge u1", st1, 4'b0101);
        ext_clk = 1'b0;
        step(4);

        // R1 reset mid-run, with load asserted
        do_load(4'b1111);
        rst      = 1'b1;
        load_en  = 1'b1;
        load_val = 4'b1010;
        step(1);
        load_en = 1'b0;
        chk("R1 reset over load u0", st0, 4'b0000);
        chk("R1 reset over load u1", st1, 4'b0000);
        rst = 1'b0;
        step(2);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule